// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This block resolves the control-flow instructions of a 32-bit RISC core that has one architectural delay slot. Each cycle it takes the program counter of the issuing instruction, the instruction word and the two source register values. From these it works out whether the instruction changes control flow, where fetch continues, whether the link register must be written, and whether the delay-slot instruction must be squashed. It handles the two-register equality compares, the sign and zero tests, the register-immediate group selected by a subfield, and the absolute jumps.

The decision is combinational, so a pipeline can act on it in the cycle it issues the instruction. On a taken transfer, fetch first goes on to the delay slot at PC + 4. The redirect to the target is registered and shows one cycle later, so the delay-slot instruction always issues before control moves. On a not-taken "likely" branch, fetch skips the slot and goes to PC + 8. A registered kill also squashes whatever instruction was already issued behind the branch. An undefined register-immediate subfield raises a trap and suppresses every other effect.

Top module: `br_resolve_unit`

## Requirements
- R1: A valid instruction whose opcode (bits 31:26) is none of 1, 2, 3, 4, 5, 6, 7, 20, 21, 22, 23 gives taken_o=0, link_we_o=0, annul_o=0, trap_o=0 and fetch_pc_o=PC+4, and no redirect or kill in the next cycle.
- R2: For the conditional opcodes 1, 4, 5, 6, 7 and 20 to 23, target_o equals PC + 4 + (sign-extended bits 15:0 shifted left by 2).
- R3: Opcodes 2 and 3 are always taken, and target_o equals PC bits 31:28 joined with bits 25:0 of the instruction and two zero bits.
- R4: Opcodes 4 and 20 are taken when the rs and rt values are equal. Opcodes 5 and 21 are taken when they differ.
- R5: Opcodes 6 and 22 are taken when rs is negative or zero. Opcodes 7 and 23 are taken when rs is positive and nonzero. In the register-immediate group, codes with bit 16 clear test rs < 0 and codes with bit 16 set test rs >= 0.
- R6: For opcode 1, bits 20:16 select the operation. Bit 17 marks the likely form and bit 20 marks a linking form. The legal codes are 0x00, 0x01, 0x02, 0x03, 0x10, 0x11, 0x12 and 0x13.
- R7: Opcode 3 and the register-immediate codes 0x10 to 0x13 assert link_we_o with link_idx_o=31 and link_data_o=PC+8, whether or not the branch is taken.
- R8: On a taken transfer, fetch_pc_o is PC+4 (the delay slot) and annul_o is 0. One cycle later redir_vld_o=1 and redir_pc_o holds the target.
- R9: A not-taken likely form (opcodes 20 to 23, codes 0x02, 0x03, 0x12, 0x13) asserts annul_o and sets fetch_pc_o=PC+8, and kill_o is 1 in the following cycle. A taken likely form behaves as in R8.
- R10: An opcode-1 instruction with any code outside R6's list asserts trap_o. It gives no taken, link write or annul in that cycle, and no redirect or kill in the next.
- R11: With valid_i low, taken_o, link_we_o, annul_o and trap_o stay 0, and no redirect or kill follows.
- R12: While rst_ni is low, redir_vld_o and kill_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction issues this cycle |
| pc_i | input | 32 | Address of the issuing instruction |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | Value of the first source register |
| rt_val_i | input | 32 | Value of the second source register |
| taken_o | output | 1 | Control transfer taken |
| target_o | output | 32 | Branch or jump target |
| fetch_pc_o | output | 32 | Next sequential fetch address (slot or skip) |
| link_we_o | output | 1 | Link register write request |
| link_idx_o | output | 5 | Link register index |
| link_data_o | output | 32 | Return address to write |
| annul_o | output | 1 | Delay slot annulled |
| trap_o | output | 1 | Undefined encoding trap |
| redir_vld_o | output | 1 | Registered redirect after the delay slot |
| redir_pc_o | output | 32 | Registered redirect address |
| kill_o | output | 1 | Registered kill of the next issued instruction |

## Verification
Each compare is driven from both sides of its decision point. Equal and unequal operand pairs separate the equality forms. Zero, a negative value with only the sign bit set, and a small positive value separate the sign and zero tests, so a test that is off by the zero case shows up. Forward and backward offsets, and a PC with high bits set, show that offsets are sign-extended and that jumps keep the upper PC bits. Likely forms are run both taken and not taken, and linking forms are run not taken, so that annulment and the unconditional link write are seen apart from the taken path. A trap-raising code and a linking code that differ only in their subfield show that the trap suppresses the link write and the redirect.

// File: rtl/br_pkg.sv
package br_pkg;
  localparam logic [5:0] OP_REGIMM = 6'd1;
  localparam logic [5:0] OP_J      = 6'd2;
  localparam logic [5:0] OP_JAL    = 6'd3;

  typedef enum logic [2:0] {
    C_NONE, C_ALWAYS, C_EQ, C_NE, C_LEZ, C_GTZ, C_LTZ, C_GEZ
  } cond_e;

  typedef struct packed {
    logic  is_ctrl;
    logic  is_jump;
    cond_e cond;
    logic  likely;
    logic  link;
    logic  undef;
  } dec_t;
endpackage

// File: rtl/br_decode.sv
module br_decode
  import br_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [4:0] sub_i,
  output dec_t       dec_o
);
  always_comb begin
    dec_o = '{is_ctrl: 1'b0, is_jump: 1'b0, cond: C_NONE,
              likely: 1'b0, link: 1'b0, undef: 1'b0};
    if (op_i == OP_REGIMM) begin
      dec_o.is_ctrl = 1'b1;
      // legal codes have bits 3:2 clear; bit0 picks >=0, bit1 likely, bit4 link
      if (sub_i[3:2] != 2'b00) begin
        dec_o.undef = 1'b1;
      end else begin
        dec_o.cond   = sub_i[0] ? C_GEZ : C_LTZ;
        dec_o.likely = sub_i[1];
        dec_o.link   = sub_i[4];
      end
    end else if (op_i == OP_J || op_i == OP_JAL) begin
      dec_o.is_ctrl = 1'b1;
      dec_o.is_jump = 1'b1;
      dec_o.cond    = C_ALWAYS;
      dec_o.link    = (op_i == OP_JAL);
    end else if ((op_i[5:2] == 4'b0001) || (op_i[5:2] == 4'b0101)) begin
      dec_o.is_ctrl = 1'b1;
      dec_o.likely  = op_i[4];
      unique case (op_i[1:0])
        2'd0:    dec_o.cond = C_EQ;
        2'd1:    dec_o.cond = C_NE;
        2'd2:    dec_o.cond = C_LEZ;
        default: dec_o.cond = C_GTZ;
      endcase
    end
  end
endmodule

// File: rtl/br_cond.sv
module br_cond
  import br_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  cond_e           cond_i,
  input  logic [XLEN-1:0] rs_i,
  input  logic [XLEN-1:0] rt_i,
  output logic            hit_o
);
  logic neg, zero, eq;
  assign neg  = rs_i[XLEN-1];
  assign zero = (rs_i == '0);
  assign eq   = (rs_i == rt_i);

  always_comb begin
    unique case (cond_i)
      C_ALWAYS: hit_o = 1'b1;
      C_EQ:     hit_o = eq;
      C_NE:     hit_o = !eq;
      C_LEZ:    hit_o = neg || zero;
      C_GTZ:    hit_o = !neg && !zero;
      C_LTZ:    hit_o = neg;
      C_GEZ:    hit_o = !neg;
      default:  hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/br_target.sv
module br_target #(
  parameter int XLEN   = 32,
  parameter int IDX_W  = 26,
  parameter int OFF_W  = 16
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             is_jump_i,
  output logic [XLEN-1:0]  target_o,
  output logic [XLEN-1:0]  seq4_o,
  output logic [XLEN-1:0]  seq8_o
);
  localparam int SEXT_W = XLEN - OFF_W - 2;
  localparam int HI_W   = XLEN - IDX_W - 2;

  logic [XLEN-1:0] br_off, br_tgt, jmp_tgt;

  assign seq4_o  = pc_i + XLEN'(4);
  assign seq8_o  = pc_i + XLEN'(8);
  assign br_off  = {{SEXT_W{idx_i[OFF_W-1]}}, idx_i[OFF_W-1:0], 2'b00};
  assign br_tgt  = seq4_o + br_off;
  assign jmp_tgt = {pc_i[XLEN-1 -: HI_W], idx_i, 2'b00};
  assign target_o = is_jump_i ? jmp_tgt : br_tgt;
endmodule

// File: rtl/br_resolve_unit.sv
module br_resolve_unit
  import br_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int REG_AW   = 5,
  parameter int LINK_REG = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [31:0]       instr_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic [XLEN-1:0]   rt_val_i,
  output logic              taken_o,
  output logic [XLEN-1:0]   target_o,
  output logic [XLEN-1:0]   fetch_pc_o,
  output logic              link_we_o,
  output logic [REG_AW-1:0] link_idx_o,
  output logic [XLEN-1:0]   link_data_o,
  output logic              annul_o,
  output logic              trap_o,
  output logic              redir_vld_o,
  output logic [XLEN-1:0]   redir_pc_o,
  output logic              kill_o
);
  dec_t            dec;
  logic            hit, act;
  logic [XLEN-1:0] seq4, seq8;

  br_decode u_dec (
    .op_i  (instr_i[31:26]),
    .sub_i (instr_i[20:16]),
    .dec_o (dec)
  );

  br_cond #(.XLEN(XLEN)) u_cond (
    .cond_i (dec.cond),
    .rs_i   (rs_val_i),
    .rt_i   (rt_val_i),
    .hit_o  (hit)
  );

  br_target #(.XLEN(XLEN), .IDX_W(26), .OFF_W(16)) u_tgt (
    .pc_i      (pc_i),
    .idx_i     (instr_i[25:0]),
    .is_jump_i (dec.is_jump),
    .target_o  (target_o),
    .seq4_o    (seq4),
    .seq8_o    (seq8)
  );

  // a trapping encoding has no other architectural effect
  assign act         = valid_i && dec.is_ctrl && !dec.undef;
  assign trap_o      = valid_i && dec.is_ctrl && dec.undef;
  assign taken_o     = act && hit;
  assign annul_o     = act && dec.likely && !hit;
  assign link_we_o   = act && dec.link;
  assign link_idx_o  = REG_AW'(LINK_REG);
  assign link_data_o = seq8;
  assign fetch_pc_o  = annul_o ? seq8 : seq4;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redir_vld_o <= 1'b0;
      redir_pc_o  <= '0;
      kill_o      <= 1'b0;
    end else begin
      redir_vld_o <= taken_o;
      kill_o      <= annul_o;
      if (taken_o) redir_pc_o <= target_o;
    end
  end
endmodule

// File: rtl/br_resolve_chk.sv
module br_resolve_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [XLEN-1:0] pc_i,
  input logic            taken_o,
  input logic [XLEN-1:0] target_o,
  input logic [XLEN-1:0] fetch_pc_o,
  input logic            link_we_o,
  input logic [XLEN-1:0] link_data_o,
  input logic            annul_o,
  input logic            trap_o,
  input logic            redir_vld_o,
  input logic [XLEN-1:0] redir_pc_o,
  input logic            kill_o
);
  p_link_ret_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> link_data_o == pc_i + XLEN'(8));

  p_slot_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> (fetch_pc_o == pc_i + XLEN'(4)) && !annul_o);

  p_redir_follows_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |=> redir_vld_o && (redir_pc_o == $past(target_o)));

  p_redir_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_vld_o |-> $past(taken_o));

  p_skip_slot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    annul_o |-> fetch_pc_o == pc_i + XLEN'(8));

  p_kill_follows_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    annul_o |=> kill_o);

  p_trap_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> !taken_o && !link_we_o && !annul_o);

  p_trap_no_redir_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> !redir_vld_o && !kill_o);

  always_comb begin
    if (!rst_ni) begin
      a_reset_idle_r12: assert (!redir_vld_o && !kill_o);
    end
  end
endmodule

bind br_resolve_unit br_resolve_chk #(.XLEN(XLEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pc_i        (pc_i),
  .taken_o     (taken_o),
  .target_o    (target_o),
  .fetch_pc_o  (fetch_pc_o),
  .link_we_o   (link_we_o),
  .link_data_o (link_data_o),
  .annul_o     (annul_o),
  .trap_o      (trap_o),
  .redir_vld_o (redir_vld_o),
  .redir_pc_o  (redir_pc_o),
  .kill_o      (kill_o)
);

// File: tb/br_resolve_unit_tb.sv
`timescale 1ns/1ps
module br_resolve_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] pc_i = '0, instr_i = '0, rs_val_i = '0, rt_val_i = '0;
  logic        taken_o, link_we_o, annul_o, trap_o, redir_vld_o, kill_o;
  logic [31:0] target_o, fetch_pc_o, link_data_o, redir_pc_o;
  logic [4:0]  link_idx_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  br_resolve_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .pc_i(pc_i),
    .instr_i(instr_i), .rs_val_i(rs_val_i), .rt_val_i(rt_val_i),
    .taken_o(taken_o), .target_o(target_o), .fetch_pc_o(fetch_pc_o),
    .link_we_o(link_we_o), .link_idx_o(link_idx_o), .link_data_o(link_data_o),
    .annul_o(annul_o), .trap_o(trap_o), .redir_vld_o(redir_vld_o),
    .redir_pc_o(redir_pc_o), .kill_o(kill_o)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_i(int op, int rs, int rt, logic [15:0] imm);
    return {op[5:0], rs[4:0], rt[4:0], imm};
  endfunction

  function automatic logic [31:0] enc_j(int op, logic [25:0] idx);
    return {op[5:0], idx};
  endfunction

  function automatic logic [31:0] br_tgt(logic [31:0] pc, logic [15:0] off);
    return pc + 32'd4 + {{14{off[15]}}, off, 2'b00};
  endfunction

  // issue one instruction at a negedge, check the decision, then the registered effects
  task automatic issue(string req, logic v, logic [31:0] pc, logic [31:0] ins,
                       logic [31:0] rs, logic [31:0] rt, logic e_tk,
                       logic [31:0] e_tgt, logic e_lnk, logic e_an, logic e_tr);
    @(negedge clk_i);
    valid_i = v; pc_i = pc; instr_i = ins; rs_val_i = rs; rt_val_i = rt;
    #1;
    chk(req, "taken", 32'(taken_o), 32'(e_tk));
    chk(req, "link_we", 32'(link_we_o), 32'(e_lnk));
    chk(req, "annul", 32'(annul_o), 32'(e_an));
    chk(req, "trap", 32'(trap_o), 32'(e_tr));
    chk(req, "fetch_pc", fetch_pc_o, e_an ? pc + 32'd8 : pc + 32'd4);
    if (e_tk) chk(req, "target", target_o, e_tgt);
    if (e_lnk) begin
      chk(req, "link_idx", 32'(link_idx_o), 32'd31);
      chk(req, "link_data", link_data_o, pc + 32'd8);
    end
    @(negedge clk_i);
    valid_i = 1'b0;
    #1;
    chk(req, "redir_vld", 32'(redir_vld_o), 32'(e_tk));
    chk(req, "kill", 32'(kill_o), 32'(e_an));
    if (e_tk) chk(req, "redir_pc", redir_pc_o, e_tgt);
  endtask

  task automatic t_reset();
    chk("R12", "redir_vld in reset", 32'(redir_vld_o), 32'd0);
    chk("R12", "kill in reset", 32'(kill_o), 32'd0);
  endtask

  task automatic t_non_ctrl();
    issue("R1", 1, 32'h0000_1000, enc_i(8, 1, 2, 16'h0010), 5, 5, 0, 0, 0, 0, 0);
    issue("R1", 1, 32'h0000_2000, enc_i(35, 3, 4, 16'hfff0), 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_equality();
    issue("R4", 1, 32'h0040_0100, enc_i(4, 1, 2, 16'h0008), 32'h55, 32'h55, 1,
          br_tgt(32'h0040_0100, 16'h0008), 0, 0, 0);
    issue("R2", 1, 32'h0040_0100, enc_i(4, 1, 2, 16'hfffc), 7, 7, 1,
          br_tgt(32'h0040_0100, 16'hfffc), 0, 0, 0);
    issue("R4", 1, 32'h0040_0200, enc_i(4, 1, 2, 16'h0008), 1, 2, 0, 0, 0, 0, 0);
    issue("R4", 1, 32'h0040_0300, enc_i(5, 1, 2, 16'h0020), 1, 2, 1,
          br_tgt(32'h0040_0300, 16'h0020), 0, 0, 0);
    issue("R4", 1, 32'h0040_0300, enc_i(5, 1, 2, 16'h0020), 9, 9, 0, 0, 0, 0, 0);
  endtask

  task automatic t_sign();
    issue("R5", 1, 32'h100, enc_i(6, 1, 0, 16'h0004), 0, 0, 1, br_tgt(32'h100, 16'h4), 0, 0, 0);
    issue("R5", 1, 32'h100, enc_i(6, 1, 0, 16'h0004), 32'h8000_0000, 0, 1,
          br_tgt(32'h100, 16'h4), 0, 0, 0);
    issue("R5", 1, 32'h100, enc_i(6, 1, 0, 16'h0004), 1, 0, 0, 0, 0, 0, 0);
    issue("R5", 1, 32'h200, enc_i(7, 1, 0, 16'h0004), 1, 0, 1, br_tgt(32'h200, 16'h4), 0, 0, 0);
    issue("R5", 1, 32'h200, enc_i(7, 1, 0, 16'h0004), 0, 0, 0, 0, 0, 0, 0);
    issue("R5", 1, 32'h200, enc_i(7, 1, 0, 16'h0004), 32'hffff_ffff, 0, 0, 0, 0, 0, 0);
    issue("R5", 1, 32'h300, enc_i(1, 1, 5'h00, 16'h0010), 32'hffff_fffe, 0, 1,
          br_tgt(32'h300, 16'h10), 0, 0, 0);
    issue("R5", 1, 32'h300, enc_i(1, 1, 5'h01, 16'h0010), 0, 0, 1,
          br_tgt(32'h300, 16'h10), 0, 0, 0);
  endtask

  task automatic t_jump();
    issue("R3", 1, 32'hA000_0040, enc_j(2, 26'h123_4567), 0, 0, 1,
          {4'hA, 26'h123_4567, 2'b00}, 0, 0, 0);
    issue("R7", 1, 32'h7FFF_FFF0, enc_j(3, 26'h000_0010), 0, 0, 1,
          {4'h7, 26'h000_0010, 2'b00}, 1, 0, 0);
  endtask

  task automatic t_regimm_link();
    // bltzal and bgezal not taken still link
    issue("R7", 1, 32'h500, enc_i(1, 1, 5'h10, 16'h0008), 32'd3, 0, 0, 0, 1, 0, 0);
    issue("R6", 1, 32'h500, enc_i(1, 1, 5'h11, 16'h0008), 32'h8000_0001, 0, 0, 0, 1, 0, 0);
    issue("R6", 1, 32'h600, enc_i(1, 1, 5'h11, 16'hff00), 32'd3, 0, 1,
          br_tgt(32'h600, 16'hff00), 1, 0, 0);
  endtask

  task automatic t_likely();
    issue("R9", 1, 32'h700, enc_i(20, 1, 2, 16'h0040), 1, 2, 0, 0, 0, 1, 0);
    issue("R9", 1, 32'h700, enc_i(20, 1, 2, 16'h0040), 4, 4, 1,
          br_tgt(32'h700, 16'h40), 0, 0, 0);
    issue("R9", 1, 32'h800, enc_i(23, 1, 0, 16'h0040), 0, 0, 0, 0, 0, 1, 0);
    issue("R9", 1, 32'h900, enc_i(1, 1, 5'h03, 16'h0040), 32'h8000_0000, 0, 0, 0, 0, 1, 0);
    issue("R6", 1, 32'h900, enc_i(1, 1, 5'h12, 16'h0040), 32'd5, 0, 0, 0, 1, 1, 0);
  endtask

  task automatic t_trap();
    issue("R10", 1, 32'hA00, enc_i(1, 1, 5'h14, 16'h0040), 32'h8000_0000, 0, 0, 0, 0, 0, 1);
    issue("R10", 1, 32'hA00, enc_i(1, 1, 5'h04, 16'h0040), 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_invalid();
    issue("R11", 0, 32'hB00, enc_i(4, 1, 2, 16'h0008), 3, 3, 0, 0, 0, 0, 0);
    issue("R11", 0, 32'hB00, enc_j(3, 26'h10), 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #7;
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_non_ctrl();
    t_equality();
    t_sign();
    t_jump();
    t_regimm_link();
    t_likely();
    t_trap();
    t_invalid();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule